// File: doc/BRIEF.md
# Sequential Stream Prefetch Engine

This block sits beside a processor's load path and watches the stream of cache-miss line addresses. It learns sequential runs of misses, upward or downward through memory, and once a run is established it sends line prefetch requests to the memory system ahead of the demand misses. The request port uses a valid/ready handshake, so the memory side can apply backpressure at any time.

Tracking is per page of 4 KB, holding 64 lines of 64 bytes each. A small fully associative table keeps up to eight streams. Each slot holds the page it owns, the most recent line missed in that page, the run direction, a confidence count and the next line to prefetch. A miss in an untracked page claims a slot in least-recently-used order. A miss in an owned page always updates that page's single slot. A stream runs at most two lines ahead of the latest demand miss and is dropped when its prefetch pointer would leave the page.

Top module: `pfx_stream_engine`

## Requirements
- R1: `miss_line` and `pf_line` are 64-byte line addresses. Bits [LINE_W-1:6] give the 4 KB page and bits [5:0] give the line within that page. A request names one whole line.
- R2: A page emits no request until it has seen three misses to adjacent lines in one direction (N, N+1, N+2 or N, N-1, N-2). On the third of these, the first request is for the line just beyond the latest miss in the run direction.
- R3: An armed stream requests lines in run order until it is two lines ahead of the latest demand miss. Each further miss in the run direction extends that window by one. The block issues at most one request per cycle.
- R4: Descending runs are trained and prefetched exactly like ascending runs, mirrored.
- R5: A miss in an owned page that does not hit the next line in the run direction resets that page's confidence to zero, and any request stops. Examples are a non-adjacent line or a step against an established direction. A new run then needs three adjacent misses again.
- R6: Each page has at most one table slot. Misses to several patterns inside one page update that one slot and so keep breaking each other.
- R7: Requests never leave the stream's page. When the prefetch pointer would pass line 63 going up, or line 0 going down, the slot is freed. A later miss in that page starts training from scratch.
- R8: The table has 8 slots. A miss to an untracked page takes a free slot, or else the least recently missed slot, whose stream is then lost.
- R9: While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_line` is unchanged.
- R10: While `rst` is high, and on the first cycle after it falls, `pf_valid` is low and the table is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A demand miss is presented this cycle |
| miss_line | input | LINE_W | Line address of the demand miss |
| pf_ready | input | 1 | Memory side accepts the request this cycle |
| pf_valid | output | 1 | A prefetch request is presented |
| pf_line | output | LINE_W | Line address to prefetch |

## Verification
A miss is captured by the table at the clock edge where it is presented. The request it triggers is registered at the following edge, so it appears on the port one cycle later, and further lines of the window follow on consecutive cycles while `pf_ready` is high. The bench drives inputs on the falling edge. It reads the port 1 ns after the falling edge, which lands between the edge that registered a request and the edge that completes its handshake. Expected lines go into an ordered queue before the miss that should cause them. After each scenario the bench waits a fixed window in which every expected line must have appeared and nothing unexpected may appear. A stalled request is checked for a stable address on each stalled cycle.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  // Run direction of a tracked stream.
  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } dir_e;

endpackage

// File: rtl/pfx_lru.sv
// Age-based least-recently-used tracker. Ages form a permutation of
// 0..N-1; the touched slot becomes 0 and younger slots age by one.
module pfx_lru #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 touch,
  input  logic [$clog2(N)-1:0] touch_idx,
  input  logic [N-1:0]         slot_valid,
  output logic [$clog2(N)-1:0] victim
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] age_q [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx)           age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + IW'(1);
      end
    end
  end

  // Free slot first (lowest index), otherwise the oldest one.
  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int i = 0; i < N; i++) begin
      if (!slot_valid[i] && !found) begin
        victim = IW'(i);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < N; i++) begin
        if (age_q[i] == IW'(N - 1)) victim = IW'(i);
      end
    end
  end

endmodule

// File: rtl/pfx_arb.sv
// Fixed-priority pick of one requesting slot, lowest index wins.
module pfx_arb #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      grant[i] = req[i] & ~taken;
      taken    = taken | req[i];
    end
  end
endmodule

// File: rtl/pfx_entry.sv
// One stream slot: page tag, last missed line, direction, confidence and
// prefetch pointer, plus its training and retire rules.
module pfx_entry
  import pfx_pkg::*;
#(
  parameter int PAGE_W  = 20,
  parameter int OFF_W   = 6,
  parameter int ARM_CNT = 2,
  parameter int DIST    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [PAGE_W-1:0] miss_page,
  input  logic [OFF_W-1:0]  miss_off,
  input  logic              alloc,
  input  logic              issue,
  output logic              match,
  output logic              want,
  output logic              slot_valid,
  output logic [PAGE_W-1:0] slot_page,
  output logic [OFF_W-1:0]  slot_pf
);
  localparam int SW = OFF_W + 2;
  localparam int CW = $clog2(ARM_CNT + 1);
  localparam logic [CW-1:0]        ARM_C  = CW'(ARM_CNT);
  localparam logic signed [SW-1:0] ONE_S  = SW'(1);
  localparam logic signed [SW-1:0] ZERO_S = '0;
  localparam logic signed [SW-1:0] DIST_S = SW'(DIST);
  localparam logic signed [SW-1:0] LAST_S = SW'((1 << OFF_W) - 1);

  logic                     v_q, v_n;
  logic [PAGE_W-1:0]        page_q, page_n;
  logic [OFF_W-1:0]         last_q, last_n;
  dir_e                     dir_q, dir_n, nd;
  logic [CW-1:0]            conf_q, conf_n;
  logic signed [SW-1:0]     pf_q, pf_n, pf_a;
  logic signed [SW-1:0]     last_s, miss_s, step_cur;
  logic                     armed, up_adj, dn_adj;

  assign last_s   = $signed({2'b00, last_q});
  assign miss_s   = $signed({2'b00, miss_off});
  assign armed    = (conf_q == ARM_C);
  assign step_cur = (dir_q == DIR_DN) ? -ONE_S : ONE_S;
  assign match    = miss_valid && v_q && (page_q == miss_page);
  assign up_adj   = (miss_s == last_s + ONE_S);
  assign dn_adj   = (miss_s == last_s - ONE_S);
  assign nd       = dn_adj ? DIR_DN : DIR_UP;

  assign want = v_q && armed &&
                ((dir_q == DIR_UP) ? (pf_q <= last_s + DIST_S)
                                   : (pf_q >= last_s - DIST_S));

  assign slot_valid = v_q;
  assign slot_page  = page_q;
  assign slot_pf    = pf_q[OFF_W-1:0];

  always_comb begin
    v_n    = v_q;
    page_n = page_q;
    last_n = last_q;
    dir_n  = dir_q;
    conf_n = conf_q;
    pf_a   = issue ? (pf_q + step_cur) : pf_q;
    pf_n   = pf_a;
    if (alloc) begin
      v_n    = 1'b1;
      page_n = miss_page;
      last_n = miss_off;
      dir_n  = DIR_UP;
      conf_n = '0;
    end else if (match) begin
      last_n = miss_off;
      if (up_adj || dn_adj) begin
        if (conf_q == '0 || nd == dir_q) begin
          dir_n = nd;
          if (armed) begin
            // Keep the pointer at least one line past the demand miss.
            if (nd == DIR_UP) pf_n = (pf_a > miss_s) ? pf_a : miss_s + ONE_S;
            else              pf_n = (pf_a < miss_s) ? pf_a : miss_s - ONE_S;
          end else begin
            conf_n = conf_q + CW'(1);
            if (conf_n == ARM_C)
              pf_n = (nd == DIR_UP) ? miss_s + ONE_S : miss_s - ONE_S;
          end
        end else begin
          conf_n = '0;
        end
      end else begin
        conf_n = '0;
      end
    end
    // Pointer leaving the page frees the slot.
    if (v_n && conf_n == ARM_C && (pf_n < ZERO_S || pf_n > LAST_S)) v_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= 1'b0;
      page_q <= '0;
      last_q <= '0;
      dir_q  <= DIR_UP;
      conf_q <= '0;
      pf_q   <= '0;
    end else begin
      v_q    <= v_n;
      page_q <= page_n;
      last_q <= last_n;
      dir_q  <= dir_n;
      conf_q <= conf_n;
      pf_q   <= pf_n;
    end
  end

  AST_PF_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
    (v_q && armed) |-> (pf_q >= ZERO_S && pf_q <= LAST_S)); // R7

  AST_LEAD_UP: assert property (@(posedge clk) disable iff (rst)
    (v_q && armed && dir_q == DIR_UP) |-> (pf_q > last_s && pf_q <= last_s + DIST_S + ONE_S)); // R3

  AST_LEAD_DN: assert property (@(posedge clk) disable iff (rst)
    (v_q && armed && dir_q == DIR_DN) |-> (pf_q < last_s && pf_q >= last_s - DIST_S - ONE_S)); // R4

endmodule

// File: rtl/pfx_stream_engine.sv
module pfx_stream_engine #(
  parameter int LINE_W     = 26,
  parameter int PAGE_BYTES = 4096,
  parameter int LINE_BYTES = 64,
  parameter int ENTRIES    = 8,
  parameter int ARM_CNT    = 2,
  parameter int DIST       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [LINE_W-1:0] miss_line,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [LINE_W-1:0] pf_line
);
  localparam int OFF_W  = $clog2(PAGE_BYTES / LINE_BYTES);
  localparam int PAGE_W = LINE_W - OFF_W;
  localparam int IW     = $clog2(ENTRIES);

  logic [PAGE_W-1:0] miss_page;
  logic [OFF_W-1:0]  miss_off;
  assign miss_page = miss_line[LINE_W-1:OFF_W];
  assign miss_off  = miss_line[OFF_W-1:0];

  logic [ENTRIES-1:0] match_v, want_v, valid_v, alloc_v, issue_v, grant_v;
  logic [PAGE_W-1:0]  page_a [ENTRIES];
  logic [OFF_W-1:0]   pfo_a  [ENTRIES];
  logic [IW-1:0]      victim, hit_idx, touch_idx;
  logic               hit, load;
  logic               pf_valid_q;
  logic [LINE_W-1:0]  pf_line_q, sel_line;

  assign hit  = |match_v;
  assign load = !pf_valid_q || pf_ready;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign alloc_v[g] = miss_valid && !hit && (victim == IW'(g));
    assign issue_v[g] = load && grant_v[g];
    pfx_entry #(
      .PAGE_W (PAGE_W),
      .OFF_W  (OFF_W),
      .ARM_CNT(ARM_CNT),
      .DIST   (DIST)
    ) i_entry (
      .clk       (clk),
      .rst       (rst),
      .miss_valid(miss_valid),
      .miss_page (miss_page),
      .miss_off  (miss_off),
      .alloc     (alloc_v[g]),
      .issue     (issue_v[g]),
      .match     (match_v[g]),
      .want      (want_v[g]),
      .slot_valid(valid_v[g]),
      .slot_page (page_a[g]),
      .slot_pf   (pfo_a[g])
    );
  end

  always_comb begin
    hit_idx  = '0;
    sel_line = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_v[i]) hit_idx  = IW'(i);
      if (grant_v[i]) sel_line = {page_a[i], pfo_a[i]};
    end
  end

  assign touch_idx = hit ? hit_idx : victim;

  pfx_lru #(.N(ENTRIES)) i_lru (
    .clk       (clk),
    .rst       (rst),
    .touch     (miss_valid),
    .touch_idx (touch_idx),
    .slot_valid(valid_v),
    .victim    (victim)
  );

  pfx_arb #(.N(ENTRIES)) i_arb (
    .req  (want_v),
    .grant(grant_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_valid_q <= 1'b0;
      pf_line_q  <= '0;
    end else if (load) begin
      pf_valid_q <= |want_v;
      pf_line_q  <= sel_line;
    end
  end

  assign pf_valid = pf_valid_q;
  assign pf_line  = pf_line_q;

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_line))); // R9

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_v)); // R6

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(issue_v)); // R3

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!pf_valid && valid_v == '0)); // R10

endmodule

// File: tb/test_pfx_stream_engine.sv
`timescale 1ns/1ps
module test_pfx_stream_engine;
  localparam int LINE_W = 26;
  localparam int OFF_W  = 6;
  localparam int PAGE_W = LINE_W - OFF_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              miss_valid = 1'b0;
  logic [LINE_W-1:0] miss_line = '0;
  logic              pf_ready = 1'b1;
  logic              pf_valid;
  logic [LINE_W-1:0] pf_line;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_req = "R10";

  logic [LINE_W-1:0] exp_q [$];
  string             tag_q [$];

  always #4 clk = ~clk;

  pfx_stream_engine i_pfx_stream_engine (
    .clk       (clk),
    .rst       (rst),
    .miss_valid(miss_valid),
    .miss_line (miss_line),
    .pf_ready  (pf_ready),
    .pf_valid  (pf_valid),
    .pf_line   (pf_line)
  );

  function automatic logic [LINE_W-1:0] la(input logic [PAGE_W-1:0] pg, input int off);
    return {pg, OFF_W'(off)};
  endfunction

  task automatic expect_pf(input logic [PAGE_W-1:0] pg, input int off, input string tag);
    exp_q.push_back(la(pg, off));
    tag_q.push_back(tag);
  endtask

  task automatic miss(input logic [PAGE_W-1:0] pg, input int off);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_line  = la(pg, off);
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic check(input bit ok, input string req, input logic [LINE_W-1:0] act,
                       input logic [LINE_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(pf_valid == 1'b0, "R10", LINE_W'(pf_valid), '0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(pf_valid == 1'b0, "R10", LINE_W'(pf_valid), '0);
  endtask

  // Wait for the window to close, then every queued line must be gone.
  task automatic drain(input string req);
    repeat (20) @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL %s actual=missing expected=%h (%0d outstanding)", req, exp_q[0], exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  // Monitor: compare each completed handshake against the queue.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && pf_valid && pf_ready) begin
        if (exp_q.size() == 0) begin
          n_checks++;
          n_fail++;
          $display("FAIL %s actual=%h expected=none", cur_req, pf_line);
        end else begin
          logic [LINE_W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(pf_line == e, t, pf_line, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [PAGE_W-1:0] pa;
    pa = 20'h12345;

    // R10 reset state
    do_reset();

    // R2 / R3 / R1: ascending run, window of two, extension by one per miss
    cur_req = "R2";
    miss(pa, 10);
    miss(pa, 11);
    expect_pf(pa, 13, "R2");
    expect_pf(pa, 14, "R3");
    miss(pa, 12);
    repeat (4) @(negedge clk);
    expect_pf(pa, 15, "R3");
    miss(pa, 13);
    expect_pf(pa, 16, "R1");
    miss(pa, 14);
    drain("R3");

    // R4: descending run mirrored
    do_reset();
    cur_req = "R4";
    miss(pa, 20);
    miss(pa, 19);
    expect_pf(pa, 17, "R4");
    expect_pf(pa, 16, "R4");
    miss(pa, 18);
    drain("R4");

    // R5: direction reversal resets, then a fresh downward run arms
    do_reset();
    cur_req = "R5";
    miss(pa, 10);
    miss(pa, 11);
    miss(pa, 10);
    miss(pa, 9);
    repeat (4) @(negedge clk);
    expect_pf(pa, 7, "R5");
    expect_pf(pa, 6, "R5");
    miss(pa, 8);
    drain("R5");

    // R5: non-adjacent jump resets
    do_reset();
    miss(pa, 30);
    miss(pa, 31);
    miss(pa, 40);
    miss(pa, 41);
    repeat (4) @(negedge clk);
    expect_pf(pa, 43, "R5");
    expect_pf(pa, 44, "R5");
    miss(pa, 42);
    drain("R5");

    // R6: two interleaved runs in one page never arm
    do_reset();
    cur_req = "R6";
    for (int k = 0; k < 4; k++) begin
      miss(pa, 10 + k);
      miss(pa, 40 + k);
    end
    drain("R6");

    // R7: top of page, one request then retire
    do_reset();
    cur_req = "R7";
    miss(pa, 60);
    miss(pa, 61);
    expect_pf(pa, 63, "R7");
    miss(pa, 62);
    drain("R7");
    miss(pa, 63);   // slot gone: retrains, no request
    drain("R7");

    // R7: arming on the last line issues nothing
    do_reset();
    miss(pa, 61);
    miss(pa, 62);
    miss(pa, 63);
    drain("R7");

    // R7 / R4: bottom of page
    do_reset();
    miss(pa, 3);
    miss(pa, 2);
    expect_pf(pa, 0, "R7");
    miss(pa, 1);
    drain("R7");

    // R8: seven other pages fit, the trained page survives
    do_reset();
    cur_req = "R8";
    miss(pa, 1);
    miss(pa, 2);
    for (int k = 1; k <= 7; k++) miss(pa + PAGE_W'(k), 10);
    expect_pf(pa, 4, "R8");
    expect_pf(pa, 5, "R8");
    miss(pa, 3);
    drain("R8");

    // R8: an eighth other page evicts the least recently missed page
    do_reset();
    miss(pa, 1);
    miss(pa, 2);
    for (int k = 1; k <= 8; k++) miss(pa + PAGE_W'(k), 10);
    miss(pa, 3);    // retrains, no request
    drain("R8");
    miss(pa + PAGE_W'(2), 11);
    expect_pf(pa + PAGE_W'(2), 13, "R8");
    expect_pf(pa + PAGE_W'(2), 14, "R8");
    miss(pa + PAGE_W'(2), 12);
    drain("R8");

    // R9: stall holds the request stable
    do_reset();
    cur_req = "R9";
    @(negedge clk);
    pf_ready = 1'b0;
    miss(pa, 10);
    miss(pa, 11);
    miss(pa, 12);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      #1;
      check(pf_valid == 1'b1 && pf_line == la(pa, 13), "R9", pf_line, la(pa, 13));
    end
    expect_pf(pa, 13, "R9");
    expect_pf(pa, 14, "R9");
    @(negedge clk);
    pf_ready = 1'b1;
    drain("R9");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule